// File: doc/BRIEF.md
# Single-Wire ROM Search Step Engine

This block carries out one step of the binary search that finds device identifiers on a single-wire open-drain bus. Each step issues two read slots. The first returns the identifier bit that every still-selected device shares. The second returns the complement of that bit. The engine then chooses a direction and sends it back in one write slot, so that devices whose bit differs drop out of the search.

The host pulses `start` together with its preferred direction, `dir_in`. That direction is only used when devices disagree, which shows as both reads returning 0. When only one read returns 1, the bus forces the direction. When both reads return 1, no device answered. The step then ends without a write slot and reports an error code.

The engine times all of its slots itself, in units of microseconds scaled by a clock-rate parameter. The bus is pulled low through `drive_low`. The line level arrives already synchronised on `line_in`. The host keeps the 64-bit identifier and the discrepancy position across steps. Bus reset is also outside this block.

Top module: `rom_step_engine`

## Requirements
- R1: After reset, `busy`, `done` and `drive_low` are 0 and `status` is 3'b000.
- R2: A `start` seen while idle begins a step: `busy` and `drive_low` are 1 in the next cycle.
- R3: A read slot drives the line low for 6 us, samples `line_in` 9 us after release, then waits a further 55 us, for 70 us in total. The 9 us point is the `TICKS_PER_US*9`-th cycle after release.
- R4: `status` is read as bit 0 = identifier bit, bit 1 = complement bit, bit 2 = direction taken. It changes only in the cycle in which `done` is 1, and it holds its value until the next `done`.
- R5: If both reads return 1, `status` is 3'b011. No write slot is issued, so `busy` lasts two read slots (140 us) before `done`.
- R6: If both reads return 0, the latched host direction is written. `status` is 3'b100 for direction 1 and 3'b000 for direction 0.
- R7: If exactly one read returns 1, the direction written equals the identifier bit. `status` is 3'b101 when that bit is 1 and 3'b010 when it is 0.
- R8: A write slot of 1 is 6 us low and then 64 us released. A write slot of 0 is 60 us low and then 10 us released. A full step therefore lasts 210 us.
- R9: `dir_in` is captured when the step starts. Changing it later in the step has no effect on the direction written or reported.
- R10: A `start` that arrives while `busy` is 1 is ignored. The step keeps its length and its three slots.
- R11: `done` is a single-cycle pulse while `busy` is 0. A `start` in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin one search step when idle |
| dir_in | input | 1 | Preferred direction for a discrepancy |
| line_in | input | 1 | Synchronised bus level |
| drive_low | output | 1 | 1 pulls the bus low |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | {direction taken, complement bit, identifier bit} |

## Verification
The completion pulse and the acceptance of a new step can fall in the same cycle, because `done` is raised after the engine is already idle. The bench provokes this by raising `start` in the very cycle in which `done` is seen. It then judges three things: the first step's status is intact in that cycle, `busy` rises in the next cycle, and the second step has the full length and its own result. A further scenario pokes `start` and flips `dir_in` in mid-step. It checks that neither the slot count nor the written direction changes.

// File: rtl/rse_pkg.sv
package rse_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_LOW, ST_RD_WAIT, ST_RD_REC, ST_WR_LOW, ST_WR_REL
   } rse_state_e;

   // packed order gives bit2 = dir, bit1 = cmp, bit0 = id
   typedef struct packed {
      logic dir;
      logic cmp;
      logic id;
   } rse_status_t;
endpackage

// File: rtl/rse_phase_timer.sv
module rse_phase_timer #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);
   logic [CW-1:0] cnt;

   // a phase loaded with N lasts N cycles; expired in its last one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val - 1'b1;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/rse_dir_decide.sv
module rse_dir_decide
   import rse_pkg::*;
(
   input  logic        id_bit,
   input  logic        cmp_bit,
   input  logic        pref_dir,
   output rse_status_t result,
   output logic        no_response
);
   always_comb begin
      no_response = id_bit & cmp_bit;
      if (no_response)
         result = '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
      else if (!id_bit && !cmp_bit)
         result = '{dir: pref_dir, cmp: 1'b0, id: 1'b0};
      else
         result = '{dir: id_bit, cmp: cmp_bit, id: id_bit};
   end
endmodule

// File: rtl/rom_step_engine.sv
module rom_step_engine
   import rse_pkg::*;
#(
   parameter int TICKS_PER_US = 200,
   parameter int SHORT_LOW_US = 6,
   parameter int SAMPLE_US    = 9,
   parameter int RD_REC_US    = 55,
   parameter int LONG_LOW_US  = 60,
   parameter int WR0_REL_US   = 10,
   parameter int WR1_REL_US   = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       dir_in,
   input  logic       line_in,
   output logic       drive_low,
   output logic       busy,
   output logic       done,
   output logic [2:0] status
);
   localparam int T_SHORT  = SHORT_LOW_US * TICKS_PER_US;
   localparam int T_SAMPLE = SAMPLE_US    * TICKS_PER_US;
   localparam int T_RDREC  = RD_REC_US    * TICKS_PER_US;
   localparam int T_LONG   = LONG_LOW_US  * TICKS_PER_US;
   localparam int T_W0REL  = WR0_REL_US   * TICKS_PER_US;
   localparam int T_W1REL  = WR1_REL_US   * TICKS_PER_US;
   localparam int T_MAX_A  = (T_LONG > T_W1REL) ? T_LONG : T_W1REL;
   localparam int T_MAX    = (T_MAX_A > T_RDREC) ? T_MAX_A : T_RDREC;
   localparam int CW       = $clog2(T_MAX + 1);

   generate
      if (TICKS_PER_US < 1) begin : g_bad_rate
         $error("TICKS_PER_US must be at least 1");
      end
      if (SHORT_LOW_US < 1 || SAMPLE_US < 1 || RD_REC_US < 1 ||
          WR0_REL_US < 1 || WR1_REL_US < 1) begin : g_bad_phase
         $error("every slot phase must last at least 1 us");
      end
      if (LONG_LOW_US <= SHORT_LOW_US) begin : g_bad_order
         $error("a written 0 must hold the line longer than a written 1");
      end
   endgenerate

   rse_state_e  state_q, state_d;
   logic        second_q, pref_q, id_q, cmp_q, wbit_q, done_q;
   rse_status_t stat_q, verdict;
   logic        no_resp, tmr_exp, tmr_load;
   logic [CW-1:0] tmr_val;

   rse_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   rse_dir_decide u_decide (
      .id_bit      (id_q),
      .cmp_bit     (cmp_q),
      .pref_dir    (pref_q),
      .result      (verdict),
      .no_response (no_resp)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = CW'(T_SHORT);
      unique case (state_q)
         ST_IDLE:
            if (start) begin
               state_d  = ST_RD_LOW;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_SHORT);
            end
         ST_RD_LOW:
            if (tmr_exp) begin
               state_d  = ST_RD_WAIT;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_SAMPLE);
            end
         ST_RD_WAIT:
            if (tmr_exp) begin
               state_d  = ST_RD_REC;
               tmr_load = 1'b1;
               tmr_val  = CW'(T_RDREC);
            end
         ST_RD_REC:
            if (tmr_exp) begin
               tmr_load = 1'b1;
               if (!second_q) begin
                  state_d = ST_RD_LOW;
                  tmr_val = CW'(T_SHORT);
               end else if (no_resp) begin
                  state_d = ST_IDLE;
               end else begin
                  state_d = ST_WR_LOW;
                  tmr_val = verdict.dir ? CW'(T_SHORT) : CW'(T_LONG);
               end
            end
         ST_WR_LOW:
            if (tmr_exp) begin
               state_d  = ST_WR_REL;
               tmr_load = 1'b1;
               tmr_val  = wbit_q ? CW'(T_W1REL) : CW'(T_W0REL);
            end
         ST_WR_REL:
            if (tmr_exp) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         second_q <= 1'b0;
         pref_q   <= 1'b0;
         id_q     <= 1'b0;
         cmp_q    <= 1'b0;
         wbit_q   <= 1'b0;
         done_q   <= 1'b0;
         stat_q   <= '0;
      end else begin
         state_q <= state_d;
         done_q  <= 1'b0;
         if (state_q == ST_IDLE && start) begin
            pref_q   <= dir_in;
            second_q <= 1'b0;
         end
         if (state_q == ST_RD_WAIT && tmr_exp) begin
            if (second_q) cmp_q <= line_in;
            else          id_q  <= line_in;
         end
         if (state_q == ST_RD_REC && tmr_exp) begin
            second_q <= 1'b1;
            wbit_q   <= verdict.dir;
            if (second_q && no_resp) begin
               stat_q <= verdict;
               done_q <= 1'b1;
            end
         end
         if (state_q == ST_WR_REL && tmr_exp) begin
            stat_q <= verdict;
            done_q <= 1'b1;
         end
      end
   end

   assign drive_low = (state_q == ST_RD_LOW) || (state_q == ST_WR_LOW);
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign status    = stat_q;
endmodule

// File: rtl/rse_chk.sv
module rse_chk #(
   parameter int TICKS_PER_US = 200,
   parameter int SHORT_LOW_US = 6,
   parameter int LONG_LOW_US  = 60
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       drive_low,
   input logic [2:0] status
);
   localparam int SHORT_T = SHORT_LOW_US * TICKS_PER_US;
   localparam int LONG_T  = LONG_LOW_US * TICKS_PER_US;

   int low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_cnt <= 0;
      else if (drive_low) low_cnt <= low_cnt + 1;
      else                low_cnt <= 0;
   end

   a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && drive_low));
   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r4_status_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(status));
   a_r7_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 3'b001 && status != 3'b110 && status != 3'b111));
   a_r3_drive_in_step: assert property (@(posedge clk) disable iff (!rst_n)
      drive_low |-> busy);
   a_r8_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_low) |-> (low_cnt == SHORT_T || low_cnt == LONG_T));
endmodule

bind rom_step_engine rse_chk #(
   .TICKS_PER_US (TICKS_PER_US),
   .SHORT_LOW_US (SHORT_LOW_US),
   .LONG_LOW_US  (LONG_LOW_US)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .drive_low (drive_low),
   .status    (status)
);

// File: tb/rom_step_engine_tb.sv
module rom_step_engine_tb;
   localparam int TPU   = 4;
   localparam int SHORT = 6 * TPU;
   localparam int LONG  = 60 * TPU;
   localparam int SAMP  = 9 * TPU;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir_in = 1'b0;
   logic drive_low, busy, done, line_in;
   logic [2:0] status;

   int checks = 0, fails = 0, cycles = 0;
   logic id_v = 1'b1, cmp_v = 1'b1;
   int slot_no = 0, rel_cnt = 0, busy_cnt = 0, wcnt = 0;
   int widths [0:7];
   logic prev_low = 1'b0;

   always #2.5 clk = ~clk;

   rom_step_engine #(.TICKS_PER_US(TPU)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
      .line_in(line_in), .drive_low(drive_low), .busy(busy),
      .done(done), .status(status)
   );

   // a device answering 0 holds the line low only around the 9 us point
   logic dev_bit;
   assign dev_bit = (slot_no == 1) ? id_v : (slot_no == 2) ? cmp_v : 1'b1;
   assign line_in = !drive_low &&
                    (dev_bit || rel_cnt < SAMP - 2 || rel_cnt > SAMP + 1);

   always @(negedge clk) begin
      if (drive_low && !prev_low) slot_no = slot_no + 1;
      prev_low = drive_low;
      if (drive_low) rel_cnt = 0;
      else           rel_cnt = rel_cnt + 1;
   end

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (busy) busy_cnt = busy_cnt + 1;
      if (drive_low) wcnt = wcnt + 1;
      else if (wcnt != 0) begin
         if (slot_no < 8) widths[slot_no] = wcnt;
         wcnt = 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      slot_no  = 0;
      busy_cnt = 0;
      for (int i = 0; i < 8; i++) widths[i] = 0;
   endtask

   task automatic wait_done(output int ok);
      ok = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done) begin ok = 1; break; end
      end
   endtask

   // run one step; poke = start again and flip dir_in mid-step
   task automatic run_step(input logic idb, input logic cmpb, input logic dir,
                           input bit poke, input logic [2:0] exp_st,
                           input string req);
      int ok;
      int nslots;
      nslots = (idb && cmpb) ? 2 : 3;
      id_v = idb; cmp_v = cmpb;
      @(negedge clk);
      clear_mon();
      dir_in = dir; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " R2 busy after start"}, busy, 1);
      check({req, " R2 drive after start"}, drive_low, 1);
      if (poke) begin
         repeat (100) @(negedge clk);
         start = 1'b1; dir_in = ~dir;
         @(negedge clk);
         start = 1'b0;
      end
      wait_done(ok);
      check({req, " done seen"}, ok, 1);
      check({req, " status"}, int'(status), int'(exp_st));
      check({req, " R11 busy low at done"}, busy, 0);
      check({req, " R3 read slot 1 low"}, widths[1], SHORT);
      check({req, " R3 read slot 2 low"}, widths[2], SHORT);
      check({req, " slot count"}, slot_no, nslots);
      check({req, " step length"}, busy_cnt, (nslots == 2) ? 140 * TPU : 210 * TPU);
      if (nslots == 3)
         check({req, " R8 write low width"}, widths[3], exp_st[2] ? SHORT : LONG);
      @(negedge clk);
      check({req, " R11 done one cycle"}, done, 0);
      check({req, " R4 status held"}, int'(status), int'(exp_st));
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 drive_low", drive_low, 0);
      check("R1 status", int'(status), 0);
   endtask

   task automatic t_back_to_back();
      int ok;
      id_v = 1'b0; cmp_v = 1'b1;
      @(negedge clk);
      clear_mon();
      dir_in = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      check("R11 first done", ok, 1);
      check("R7 first status 010", int'(status), 3'b010);
      id_v = 1'b0; cmp_v = 1'b0;
      clear_mon();
      dir_in = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R11 start on done accepted", busy, 1);
      check("R11 old status kept", int'(status), 3'b010);
      wait_done(ok);
      check("R11 second done", ok, 1);
      check("R6 second status 100", int'(status), 3'b100);
      check("R11 second length", busy_cnt, 210 * TPU);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) widths[i] = 0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      run_step(1'b0, 1'b0, 1'b1, 1'b0, 3'b100, "R6 dir1");
      run_step(1'b0, 1'b0, 1'b0, 1'b0, 3'b000, "R6 dir0");
      run_step(1'b1, 1'b0, 1'b0, 1'b0, 3'b101, "R7 id1");
      run_step(1'b0, 1'b1, 1'b1, 1'b0, 3'b010, "R7 id0");
      run_step(1'b1, 1'b1, 1'b0, 1'b0, 3'b011, "R5 none");
      run_step(1'b0, 1'b0, 1'b1, 1'b1, 3'b100, "R9 R10 poke dir1");
      run_step(1'b0, 1'b0, 1'b0, 1'b1, 3'b000, "R9 R10 poke dir0");
      t_back_to_back();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule